// File: doc/BRIEF.md
# Vertical Sync De-interlace Sampler

This block turns an asynchronous vertical sync input into a one-clock vertical reset pulse aligned to the system clock. Both reference inputs pass through a two-flop synchronizer. The vertical input then goes through a glitch filter that accepts a new level only after it has held for a programmable number of clocks.

The block has two modes. In direct mode the filtered vertical level is watched on every clock, and its leading edge fires the reset. In de-interlace mode a line counter is restarted by the rising edge of the horizontal reference. The vertical level is then sampled once per line, at one of two positions. The two positions are half a line apart. An interlaced field whose sync arrives half a line late is therefore caught at the same line phase as the other field.

A polarity bit selects which vertical edge counts as leading. If the horizontal reference stops, the line counter free-runs with the same period, so sampling goes on at the programmed positions.

Top module: `vsync_deint_sampler`

## Requirements
- R1: While reset is asserted and after its release, `vreset_o` stays low until a qualifying leading edge or sample occurs; a vertical input that is inactive at release produces no pulse.
- R2: With `direct_mode_i`=1, a leading edge applied to `vref_i` just before clock edge n gives one pulse on `vreset_o`, high after clock edge n+4 and low after edge n+5; a steady vertical level gives none.
- R3: `fall_lead_i`=0 makes a rising `vref_i` the leading edge and `fall_lead_i`=1 makes a falling one; the trailing edge never produces a pulse.
- R4: A `vref_i` level that lasts fewer than MIN_WIDTH (default 2) clocks is ignored; a level that lasts MIN_WIDTH clocks or more is accepted.
- R5: A rising `href_i` edge applied just before clock edge n restarts the line. A sampling position P then takes the vertical level that was applied before edge n+P-1, and a resulting pulse is high after edge n+3+P. A line is LINE_LEN (default 432) clocks long.
- R6: With `direct_mode_i`=0, the sampling position is 42 clocks when `late_phase_i`=0 and 258 clocks when `late_phase_i`=1. These are exactly half a line apart. No pulse occurs at any other line position.
- R7: In de-interlace mode a pulse fires only at the first sampling point that sees the vertical level active after a sampling point that saw it inactive. A level held active over several lines gives one pulse, and an edge between sampling points waits for the next point.
- R8: Without horizontal edges the line counter wraps after LINE_LEN clocks, so de-interlaced sampling continues at the same positions with the same period.
- R9: Every pulse on `vreset_o` is exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| href_i | input | 1 | Asynchronous horizontal reference; rising edge starts a line |
| vref_i | input | 1 | Asynchronous vertical sync input |
| direct_mode_i | input | 1 | 1: direct edge detection, 0: de-interlaced sampling |
| late_phase_i | input | 1 | De-interlace sampling position: 0 early, 1 late (half a line later) |
| fall_lead_i | input | 1 | 0: rising edge is leading, 1: falling edge is leading |
| vreset_o | output | 1 | One-clock vertical reset pulse |

## Verification
The bench times each pulse to the exact clock edge through the synchronizer, filter and output register. A design with one register too many or too few therefore misplaces every pulse. It sends one-clock glitches and two-clock pulses: a filter that is off by one either passes the glitch or drops the valid pulse. In de-interlace mode it holds the vertical input active for several lines and raises it after the sampling point. A sampler that fires on raw edges or on every active sample gives extra or early pulses. It also removes the horizontal reference. A counter that stalls or wraps at the wrong count then loses or shifts the pulse of the next field.

// File: rtl/vds_pkg.sv
package vds_pkg;

    typedef enum logic {
        SCAN_DEINT  = 1'b0,
        SCAN_DIRECT = 1'b1
    } scan_mode_e;

    typedef enum logic {
        LEAD_RISE = 1'b0,
        LEAD_FALL = 1'b1
    } lead_edge_e;

    typedef struct packed {
        logic act_prev;
        logic sampled;
        logic pulse;
    } pick_state_t;

endpackage

// File: rtl/vds_sync.sv
module vds_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/vds_glitch_filter.sv
module vds_glitch_filter #(
    parameter int MIN_WIDTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic lvl_o
);

    localparam int CW = (MIN_WIDTH < 2) ? 1 : $clog2(MIN_WIDTH + 1);
    localparam logic [CW:0] MIN_C = (CW + 1)'(MIN_WIDTH);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] run;
    } filt_state_t;

    filt_state_t st_d, st_q;
    logic [CW:0] run_next;

    assign run_next = {1'b0, st_q.run} + (CW + 1)'(1);

    generate
        if (MIN_WIDTH <= 1) begin : g_pass
            always_comb begin
                st_d     = st_q;
                st_d.lvl = lvl_i;
                st_d.run = '0;
            end
        end else begin : g_run
            always_comb begin
                st_d = st_q;
                if (lvl_i == st_q.lvl) begin
                    st_d.run = '0;
                end else if (run_next >= MIN_C) begin
                    st_d.lvl = lvl_i;
                    st_d.run = '0;
                end else begin
                    st_d.run = run_next[CW-1:0];
                end
            end

            AST_FILT_HELD_TWO: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(st_q.lvl) |-> ($past(lvl_i, 2) == st_q.lvl)); // R4
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.lvl;

    AST_FILT_FROM_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.lvl) |-> ($past(lvl_i) == st_q.lvl)); // R4

endmodule

// File: rtl/vds_line_timer.sv
module vds_line_timer #(
    parameter int LINE_LEN = 432,
    localparam int PW = $clog2(LINE_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          href_lvl_i,
    output logic [PW-1:0] pos_o
);

    localparam logic [PW-1:0] LAST_C = PW'(LINE_LEN - 1);

    typedef struct packed {
        logic          prev;
        logic [PW-1:0] cnt;
    } line_state_t;

    line_state_t st_d, st_q;
    logic        start_w;

    assign start_w = href_lvl_i & ~st_q.prev;

    always_comb begin
        st_d      = st_q;
        st_d.prev = href_lvl_i;
        if (start_w || st_q.cnt == LAST_C) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o = st_q.cnt;

    AST_LINE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (href_lvl_i && !st_q.prev) |=> (pos_o == '0)); // R5

    AST_LINE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_o == LAST_C) |=> (pos_o == '0)); // R8

    AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!href_lvl_i && pos_o != LAST_C) |=> (pos_o == $past(pos_o) + PW'(1))); // R8

endmodule

// File: rtl/vsync_deint_sampler.sv
module vsync_deint_sampler #(
    parameter int LINE_LEN    = 432,
    parameter int EARLY_POS   = 42,
    parameter int LATE_POS    = 258,
    parameter int MIN_WIDTH   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic href_i,
    input  logic vref_i,
    input  logic direct_mode_i,
    input  logic late_phase_i,
    input  logic fall_lead_i,
    output logic vreset_o
);

    import vds_pkg::*;

    localparam int PW = $clog2(LINE_LEN);
    localparam logic [PW-1:0] EARLY_C = PW'(EARLY_POS);
    localparam logic [PW-1:0] LATE_C  = PW'(LATE_POS);

    logic          href_s, vref_s, vref_f;
    logic [PW-1:0] pos_w;
    logic          act_w, at_sample_w, direct_hit_w, deint_hit_w;
    scan_mode_e    mode_w;
    lead_edge_e    lead_w;
    pick_state_t   st_d, st_q;

    vds_sync #(.STAGES(SYNC_STAGES)) u_href_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(href_i),
        .sync_o (href_s)
    );

    vds_sync #(.STAGES(SYNC_STAGES)) u_vref_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(vref_i),
        .sync_o (vref_s)
    );

    vds_glitch_filter #(.MIN_WIDTH(MIN_WIDTH)) u_vref_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl_i(vref_s),
        .lvl_o(vref_f)
    );

    vds_line_timer #(.LINE_LEN(LINE_LEN)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .href_lvl_i(href_s),
        .pos_o     (pos_w)
    );

    assign mode_w       = scan_mode_e'(direct_mode_i);
    assign lead_w       = lead_edge_e'(fall_lead_i);
    assign act_w        = (lead_w == LEAD_FALL) ? ~vref_f : vref_f;
    assign at_sample_w  = (pos_w == (late_phase_i ? LATE_C : EARLY_C));
    assign direct_hit_w = act_w & ~st_q.act_prev;
    assign deint_hit_w  = at_sample_w & act_w & ~st_q.sampled;

    always_comb begin
        st_d          = st_q;
        st_d.act_prev = act_w;
        if (at_sample_w) begin
            st_d.sampled = act_w;
        end
        st_d.pulse = (mode_w == SCAN_DIRECT) ? direct_hit_w : deint_hit_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.act_prev <= 1'b1;
            st_q.sampled  <= 1'b1;
            st_q.pulse    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vreset_o = st_q.pulse;

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        vreset_o |=> !vreset_o); // R9

    AST_DEINT_ONLY_AT_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct_mode_i && pos_w != EARLY_C && pos_w != LATE_C) |=> !vreset_o); // R6

    AST_DIRECT_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (direct_mode_i && $stable(vref_f) && $stable(fall_lead_i)) |=> !vreset_o); // R2

    AST_DEINT_SEES_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct_mode_i && !act_w) |=> !vreset_o); // R7

endmodule

// File: tb/test_vsync_deint_sampler.sv
`timescale 1ns/1ps
module test_vsync_deint_sampler;

    localparam int LINE = 432;
    localparam int EARLY = 42;
    localparam int LATE = 258;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic href_i = 1'b0;
    logic vref_i = 1'b0;
    logic direct_mode_i = 1'b1;
    logic late_phase_i = 1'b0;
    logic fall_lead_i = 1'b0;
    logic vreset_o;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    int unexpected = 0;
    int unexp_seen = 0;
    bit done = 1'b0;

    typedef struct {
        int    at;
        string tag;
    } exp_t;
    exp_t q[$];

    vsync_deint_sampler i_vsync_deint_sampler (
        .clk          (clk),
        .rst_n        (rst_n),
        .href_i       (href_i),
        .vref_i       (vref_i),
        .direct_mode_i(direct_mode_i),
        .late_phase_i (late_phase_i),
        .fall_lead_i  (fall_lead_i),
        .vreset_o     (vreset_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor: pops expected pulses and compares arrival cycles
    always @(negedge clk) begin
        if (rst_n) begin
            if (q.size() > 0 && cyc > q[0].at) begin
                checks++;
                errors++;
                $display("FAIL %s: pulse missing, actual none at cycle %0d expected cycle %0d",
                         q[0].tag, cyc, q[0].at);
                void'(q.pop_front());
            end
            if (vreset_o) begin
                if (q.size() > 0 && q[0].at == cyc) begin
                    checks++;
                    void'(q.pop_front());
                end else begin
                    unexpected++;
                end
            end
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_pulse(input int at, input string tag);
        exp_t e;
        e.at  = at;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic check_quiet(input string tag);
        checks++;
        if (unexpected != unexp_seen) begin
            errors++;
            $display("FAIL %s: unexpected pulses actual %0d expected 0",
                     tag, unexpected - unexp_seen);
        end
        unexp_seen = unexpected;
    endtask

    // one line of LINE clocks; href high for 8 clocks at start when with_href
    task automatic run_line(input bit with_href, input int rise_off, input int fall_off,
                            output int start);
        start = cyc;
        for (int i = 0; i < LINE; i++) begin
            href_i = with_href && (i < 8);
            if (i == rise_off) vref_i = 1'b1;
            if (i == fall_off) vref_i = 1'b0;
            step();
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        finish_run();
    end

    initial begin
        int h;
        int k;
        // R1: reset state
        step(3);
        checks++;
        if (vreset_o !== 1'b0) begin
            errors++;
            $display("FAIL R1: during reset actual %b expected 0", vreset_o);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            step();
            checks++;
            if (vreset_o !== 1'b0) begin
                errors++;
                $display("FAIL R1: after release actual %b expected 0", vreset_o);
            end
        end
        unexp_seen = unexpected;

        // R2 / R3: direct mode, rising edge leading
        direct_mode_i = 1'b1;
        fall_lead_i   = 1'b0;
        k = cyc; vref_i = 1'b1; expect_pulse(k + 5, "R2 direct rise");
        step(20);
        vref_i = 1'b0;  // trailing edge
        step(20);
        check_quiet("R3 trailing edge ignored");
        check_quiet("R9 single-cycle pulse");

        // R4: glitch filter
        vref_i = 1'b1; step(); vref_i = 1'b0;
        step(20);
        check_quiet("R4 one-clock glitch ignored");
        k = cyc; vref_i = 1'b1; expect_pulse(k + 5, "R4 two-clock pulse accepted");
        step(2); vref_i = 1'b0;
        step(20);
        check_quiet("R4 no extra pulse");

        // R3: falling edge leading
        k = cyc; vref_i = 1'b1; expect_pulse(k + 5, "R3 rise before polarity change");
        step(20);
        fall_lead_i = 1'b1;
        step(20);
        check_quiet("R3 polarity switch while high");
        k = cyc; vref_i = 1'b0; expect_pulse(k + 5, "R3 falling leading edge");
        step(20);
        vref_i = 1'b1; step(20);
        check_quiet("R3 rising is trailing under fall polarity");
        vref_i = 1'b0; k = cyc; expect_pulse(k + 5, "R3 second falling edge");
        step(20);
        fall_lead_i = 1'b0;
        step(20);
        check_quiet("R2 steady level after polarity restore");

        // de-interlace mode, early phase
        direct_mode_i = 1'b0;
        late_phase_i  = 1'b0;
        run_line(1'b1, -1, -1, h);
        run_line(1'b1, -1, -1, h);
        check_quiet("R7 inactive lines");
        h = cyc; expect_pulse(h + 4 + EARLY, "R6 early sampling point");
        run_line(1'b1, 10, -1, h);
        run_line(1'b1, -1, -1, h);
        run_line(1'b1, -1, 100, h);
        check_quiet("R7 held level gives one pulse");
        run_line(1'b1, -1, -1, h);
        run_line(1'b1, 100, -1, h);  // rise after the point of this line
        h = cyc; expect_pulse(h + 4 + EARLY, "R7 edge waits for next point");
        run_line(1'b1, -1, 300, h);
        run_line(1'b1, -1, -1, h);
        check_quiet("R6 no pulse off sampling point");

        // late phase
        late_phase_i = 1'b1;
        run_line(1'b1, -1, -1, h);
        h = cyc; expect_pulse(h + 4 + LATE, "R6 late sampling point");
        run_line(1'b1, 100, -1, h);
        run_line(1'b1, -1, 300, h);
        run_line(1'b1, -1, -1, h);
        h = cyc; expect_pulse(h + 4 + LATE, "R5 late point half a line after early");
        run_line(1'b1, 30, 400, h);
        run_line(1'b1, -1, -1, h);
        check_quiet("R7 late phase single pulse");

        // R8: free-running line counter
        late_phase_i = 1'b0;
        run_line(1'b1, -1, -1, h);
        run_line(1'b1, -1, -1, h);
        run_line(1'b0, 200, -1, h);
        h = cyc; expect_pulse(h + 4 + EARLY, "R8 free-run wrap keeps position");
        run_line(1'b0, -1, 100, h);
        run_line(1'b0, -1, -1, h);
        check_quiet("R8 free-run no extra pulse");

        step(10);
        while (q.size() > 0) begin
            checks++;
            errors++;
            $display("FAIL %s: pulse missing, actual none expected cycle %0d", q[0].tag, q[0].at);
            void'(q.pop_front());
        end
        check_quiet("R9 final quiet");
        finish_run();
    end

endmodule